// File: doc/BRIEF.md
# Stencil Accelerator Control Sequencer

This block sequences a 3×3 edge-detection accelerator across a monochrome image of 8-bit pixels stored row after row in 32-bit memory words, four pixels to a word with the leftmost pixel in the most significant byte. A single start pulse sets it walking the output rows. For each output row it steps through column groups of four pixels. In each group it fetches, over a bus-master port, the word above, the word at and the word below the output row. It also writes back one word holding four finished result pixels. Alongside the bus traffic it drives the strobes an external pixel pipeline needs: one load pulse per fetched row word and a shift enable that advances the 3×3 window by one pixel per cycle.

The row schedule is deliberately lopsided. The pipeline has a latency of a little over one group, so the first two groups of a row only fetch. From the third group on, every group begins by storing the word finished two groups earlier. After the last group of a row has been fetched and shifted, one more write is issued. That write is followed by a run of drain shifts with no fetch and then the final write of the row. When the final write of the last output row is acknowledged, the block raises a done flag and returns to idle. The done flag stays set until a status-read pulse clears it, and it drives an interrupt request whenever the interrupt-enable input is high.

The external register decoder supplies the two word-granular base addresses and the start, enable and status-read pulses. The datapath and the bus arbiter are also outside the block.

States: `SQ_IDLE`, `SQ_RD_PREV`, `SQ_RD_CURR`, `SQ_RD_NEXT`, `SQ_SHIFT`, `SQ_WRITE`. Transitions: idle→prev on start (counters cleared). prev→curr, curr→next and next→shift, each on acknowledge. After the last shift cycle, shift→prev for the first group and shift→write otherwise. On acknowledge, write→prev while fetch groups remain. Write→shift for the drain step. Write→prev at the end of a row that is not the last. Write→idle at the end of the last row, which also sets done.

Top module: `stencil_seq`

## Requirements
- R1: After reset the block is idle. Bus request, write enable, all load strobes, shift enable, done and interrupt are 0.
- R2: A start pulse while idle begins a frame. The first bus access is a read at `src_base_i`. A start pulse while a frame is in progress has no effect on the access sequence.
- R3: Each group fetches three words in the fixed order above, at, below. The addresses are the group's word address, plus WPR, plus 2×WPR (WPR = image width / pixels per word). Exactly one of `ld_prev_o`, `ld_curr_o`, `ld_next_o` pulses in the acknowledge cycle of the matching read, and none at any other time.
- R4: Once raised, the request holds its address and write enable unchanged until the acknowledge cycle.
- R5: After the third read of a group, and in each drain step, `shift_en_o` is high for exactly PIX_PER_WORD consecutive cycles, with no bus request during that time.
- R6: The first two groups of every row are fetched with no write. The row's first write comes right before the third group's fetches.
- R7: A row ends with a write, a PIX_PER_WORD-cycle drain shift, and a second write, with no reads in between.
- R8: Row r, group g fetches its upper word at `src_base_i` + r×WPR + g. The k-th write of a frame goes to `dst_base_i` + k. A frame has (height−2)×WPR writes and 3×(height−2)×WPR reads.
- R9: With a standard window pipeline on the strobes, the write at `dst_base_i` + r×WPR + g holds the results for centre columns 4g…4g+3 of image row r+1, leftmost in bits 31:24. Each result is bits 10:3 of |Dx|+|Dy|. Interior columns match a software stencil.
- R10: `done_o` rises on the acknowledge of the last write of the last output row, and the block returns to idle. `done_o` stays high until `status_rd_i` pulses and is 0 on the next cycle after that pulse.
- R11: `irq_o` is high exactly when `done_o` and `irq_en_i` are both high.
- R12: A new start after a finished frame restarts both address offsets and the row and group counters from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse from register decoder |
| irq_en_i | input | 1 | Interrupt enable level |
| status_rd_i | input | 1 | Status-read pulse, clears done |
| src_base_i | input | AW | Word address of source image row 0 |
| dst_base_i | input | AW | Word address of first result word |
| m_cyc_o | output | 1 | Bus cycle request |
| m_stb_o | output | 1 | Bus strobe |
| m_we_o | output | 1 | 1 = write, 0 = read |
| m_adr_o | output | AW | Word address |
| m_ack_i | input | 1 | Bus acknowledge |
| ld_prev_o | output | 1 | Load upper row word into datapath |
| ld_curr_o | output | 1 | Load centre row word into datapath |
| ld_next_o | output | 1 | Load lower row word into datapath |
| shift_en_o | output | 1 | Advance window pipeline one pixel |
| done_o | output | 1 | Frame finished flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a start pulse that lands in the middle of a frame while memory is inserting wait states. Only then do request holding and busy-start rejection both matter. The bench runs a second frame with a two-cycle wait memory and pulses start about forty cycles into it. It then compares the full logged access sequence against a computed schedule, and a model window pipeline driven only by the strobes checks every interior result byte against a software stencil.

// File: rtl/stencil_seq_pkg.sv
package stencil_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_RD_PREV = 3'd1,
        SQ_RD_CURR = 3'd2,
        SQ_RD_NEXT = 3'd3,
        SQ_SHIFT   = 3'd4,
        SQ_WRITE   = 3'd5
    } sq_state_t;

    typedef struct packed {
        logic has_read;
        logic has_shift;
        logic first_col;
        logic shift_last;
        logic row_last;
    } sq_flags_t;

endpackage

// File: rtl/stencil_seq_counters.sv
module stencil_seq_counters
    import stencil_seq_pkg::*;
#(
    parameter int WPR      = 160,
    parameter int OUT_ROWS = 478,
    parameter int PPW      = 4,
    localparam int CW      = $clog2(WPR + 2),
    localparam int RW      = $clog2((OUT_ROWS > 1) ? OUT_ROWS : 2),
    localparam int SW      = $clog2((PPW > 1) ? PPW : 2)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clr_i,
    input  logic          shift_i,
    input  logic          col_step_i,
    input  logic          row_step_i,
    output sq_flags_t     flags_o,
    output logic [CW-1:0] col_o
);

    localparam logic [CW-1:0] C_WPR  = CW'(WPR);
    localparam logic [CW-1:0] C_LAST = CW'(WPR + 1);
    localparam logic [RW-1:0] R_LAST = RW'(OUT_ROWS - 1);
    localparam logic [SW-1:0] S_LAST = SW'(PPW - 1);

    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic [SW-1:0] sh_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            col_q <= '0;
            row_q <= '0;
        end else if (row_step_i) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
        end else if (col_step_i) begin
            col_q <= col_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            sh_q <= '0;
        end else if (shift_i) begin
            sh_q <= (sh_q == S_LAST) ? '0 : sh_q + 1'b1;
        end
    end

    always_comb begin
        flags_o.has_read   = (col_q < C_WPR);
        flags_o.has_shift  = (col_q <= C_WPR);
        flags_o.first_col  = (col_q == '0);
        flags_o.shift_last = (sh_q == S_LAST);
        flags_o.row_last   = (row_q == R_LAST);
    end

    assign col_o = col_q;

    // R5: the shift-cycle counter wraps after PPW cycles
    a_r5_shift_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_i && sh_q == S_LAST && !clr_i) |=> (sh_q == '0));

    // R7: the group counter never passes the second drain step
    a_r7_col_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        col_q <= C_LAST);

endmodule

// File: rtl/stencil_seq_fsm.sv
module stencil_seq_fsm
    import stencil_seq_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      start_i,
    input  logic      ack_i,
    input  sq_flags_t flags_i,
    output sq_state_t state_o,
    output logic      cyc_o,
    output logic      we_o,
    output logic [2:0] ld_o,
    output logic      shift_o,
    output logic      clr_o,
    output logic      col_step_o,
    output logic      row_step_o,
    output logic      o_step_o,
    output logic      d_step_o,
    output logic      done_set_o
);

    sq_state_t st_q, st_d;
    logic      row_end;

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= SQ_IDLE;
        else       st_q <= st_d;
    end

    assign row_end = ack_i && !flags_i.has_read && !flags_i.has_shift;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:    if (start_i) st_d = SQ_RD_PREV;
            SQ_RD_PREV: if (ack_i)   st_d = SQ_RD_CURR;
            SQ_RD_CURR: if (ack_i)   st_d = SQ_RD_NEXT;
            SQ_RD_NEXT: if (ack_i)   st_d = SQ_SHIFT;
            SQ_SHIFT:
                if (flags_i.shift_last)
                    st_d = flags_i.first_col ? SQ_RD_PREV : SQ_WRITE;
            SQ_WRITE:
                if (ack_i) begin
                    if (flags_i.has_read)       st_d = SQ_RD_PREV;
                    else if (flags_i.has_shift) st_d = SQ_SHIFT;
                    else if (flags_i.row_last)  st_d = SQ_IDLE;
                    else                        st_d = SQ_RD_PREV;
                end
            default:                            st_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        cyc_o      = 1'b0;
        we_o       = 1'b0;
        ld_o       = 3'b000;
        shift_o    = 1'b0;
        clr_o      = 1'b0;
        col_step_o = 1'b0;
        row_step_o = 1'b0;
        o_step_o   = 1'b0;
        d_step_o   = 1'b0;
        done_set_o = 1'b0;
        unique case (st_q)
            SQ_IDLE:    clr_o = start_i;
            SQ_RD_PREV: begin cyc_o = 1'b1; ld_o[0] = ack_i; end
            SQ_RD_CURR: begin cyc_o = 1'b1; ld_o[1] = ack_i; end
            SQ_RD_NEXT: begin cyc_o = 1'b1; ld_o[2] = ack_i; o_step_o = ack_i; end
            SQ_SHIFT: begin
                shift_o    = 1'b1;
                col_step_o = flags_i.shift_last;
            end
            SQ_WRITE: begin
                cyc_o      = 1'b1;
                we_o       = 1'b1;
                d_step_o   = ack_i;
                row_step_o = row_end && !flags_i.row_last;
                done_set_o = row_end && flags_i.row_last;
            end
            default: ;
        endcase
    end

    assign state_o = st_q;

    // R4: a raised request stays raised until acknowledged
    a_r4_req_held: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_o && !ack_i) |=> (cyc_o && $stable(we_o)));

    // R2: a start pulse outside idle never clears the counters
    a_r2_busy_start: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q != SQ_IDLE && start_i) |-> !clr_o);

endmodule

// File: rtl/stencil_seq_addr.sv
module stencil_seq_addr
    import stencil_seq_pkg::*;
#(
    parameter int AW  = 20,
    parameter int WPR = 160
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clr_i,
    input  logic          o_step_i,
    input  logic          d_step_i,
    input  sq_state_t     state_i,
    input  logic [AW-1:0] src_base_i,
    input  logic [AW-1:0] dst_base_i,
    output logic [AW-1:0] adr_o
);

    logic [AW-1:0] o_off_q;
    logic [AW-1:0] d_off_q;
    logic [AW-1:0] rd_adr [3];

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            o_off_q <= '0;
            d_off_q <= '0;
        end else begin
            if (o_step_i) o_off_q <= o_off_q + 1'b1;
            if (d_step_i) d_off_q <= d_off_q + 1'b1;
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_row_adr
        assign rd_adr[k] = src_base_i + o_off_q + AW'(k * WPR);
    end

    always_comb begin
        unique case (state_i)
            SQ_RD_PREV: adr_o = rd_adr[0];
            SQ_RD_CURR: adr_o = rd_adr[1];
            SQ_RD_NEXT: adr_o = rd_adr[2];
            SQ_WRITE:   adr_o = dst_base_i + d_off_q;
            default:    adr_o = '0;
        endcase
    end

    // R8: every write trails the fetches that feed it
    a_r8_write_lags_read: assert property (@(posedge clk_i) disable iff (rst_i)
        d_step_i |-> (d_off_q < o_off_q));

endmodule

// File: rtl/stencil_seq_status.sv
module stencil_seq_status (
    input  logic clk_i,
    input  logic rst_i,
    input  logic done_set_i,
    input  logic status_rd_i,
    input  logic irq_en_i,
    output logic done_o,
    output logic irq_o
);

    logic done_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)            done_q <= 1'b0;
        else if (done_set_i)  done_q <= 1'b1;
        else if (status_rd_i) done_q <= 1'b0;
    end

    assign done_o = done_q;
    assign irq_o  = done_q && irq_en_i;

    // R10: done persists until a status read
    a_r10_done_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_q && !status_rd_i) |=> done_q);

    // R10: a status read without a coincident set clears done
    a_r10_done_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_rd_i && !done_set_i) |=> !done_q);

endmodule

// File: rtl/stencil_seq.sv
module stencil_seq
    import stencil_seq_pkg::*;
#(
    parameter int IMG_W        = 640,
    parameter int IMG_H        = 480,
    parameter int PIX_PER_WORD = 4,
    parameter int AW           = 20,
    localparam int WPR         = IMG_W / PIX_PER_WORD,
    localparam int OUT_ROWS    = IMG_H - 2,
    localparam int CW          = $clog2(WPR + 2)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic          irq_en_i,
    input  logic          status_rd_i,
    input  logic [AW-1:0] src_base_i,
    input  logic [AW-1:0] dst_base_i,
    output logic          m_cyc_o,
    output logic          m_stb_o,
    output logic          m_we_o,
    output logic [AW-1:0] m_adr_o,
    input  logic          m_ack_i,
    output logic          ld_prev_o,
    output logic          ld_curr_o,
    output logic          ld_next_o,
    output logic          shift_en_o,
    output logic          done_o,
    output logic          irq_o
);

    localparam logic [CW-1:0] C_WPR = CW'(WPR);

    sq_state_t     state;
    sq_flags_t     flags;
    logic [CW-1:0] col;
    logic [2:0]    ld;
    logic          clr, col_step, row_step, o_step, d_step, done_set;

    stencil_seq_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start_i),
        .ack_i      (m_ack_i),
        .flags_i    (flags),
        .state_o    (state),
        .cyc_o      (m_cyc_o),
        .we_o       (m_we_o),
        .ld_o       (ld),
        .shift_o    (shift_en_o),
        .clr_o      (clr),
        .col_step_o (col_step),
        .row_step_o (row_step),
        .o_step_o   (o_step),
        .d_step_o   (d_step),
        .done_set_o (done_set)
    );

    stencil_seq_counters #(
        .WPR      (WPR),
        .OUT_ROWS (OUT_ROWS),
        .PPW      (PIX_PER_WORD)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_i      (clr),
        .shift_i    (shift_en_o),
        .col_step_i (col_step),
        .row_step_i (row_step),
        .flags_o    (flags),
        .col_o      (col)
    );

    stencil_seq_addr #(
        .AW  (AW),
        .WPR (WPR)
    ) u_addr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_i      (clr),
        .o_step_i   (o_step),
        .d_step_i   (d_step),
        .state_i    (state),
        .src_base_i (src_base_i),
        .dst_base_i (dst_base_i),
        .adr_o      (m_adr_o)
    );

    stencil_seq_status u_stat (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .done_set_i  (done_set),
        .status_rd_i (status_rd_i),
        .irq_en_i    (irq_en_i),
        .done_o      (done_o),
        .irq_o       (irq_o)
    );

    assign m_stb_o   = m_cyc_o;
    assign ld_prev_o = ld[0];
    assign ld_curr_o = ld[1];
    assign ld_next_o = ld[2];

    // R3: at most one load strobe, and only on a read acknowledge
    a_r3_load_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({ld_prev_o, ld_curr_o, ld_next_o}));
    a_r3_load_on_ack: assert property (@(posedge clk_i) disable iff (rst_i)
        (ld_prev_o || ld_curr_o || ld_next_o) |-> (m_ack_i && !m_we_o));

    // R4: address stable while a request waits
    a_r4_adr_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        (m_cyc_o && !m_ack_i) |=> $stable(m_adr_o));

    // R5: no bus activity while the window shifts
    a_r5_quiet_shift: assert property (@(posedge clk_i) disable iff (rst_i)
        shift_en_o |-> !m_cyc_o);

    // R6: no write during the first two groups of a row
    a_r6_no_early_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (m_cyc_o && m_we_o) |-> (col >= CW'(2)));

    // R7: no read once the row is draining
    a_r7_no_late_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (m_cyc_o && !m_we_o) |-> (col < C_WPR));

endmodule

// File: tb/stencil_seq_test.sv
`timescale 1ns/1ps
module stencil_seq_test;

    localparam int W    = 16;
    localparam int H    = 6;
    localparam int PPW  = 4;
    localparam int AW   = 12;
    localparam int WPR  = W / PPW;
    localparam int OR   = H - 2;
    localparam int SRC  = 'h100;
    localparam int DST  = 'h400;
    localparam int NACC = OR * 4 * WPR;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          start = 1'b0, irq_en = 1'b0, status_rd = 1'b0;
    logic [AW-1:0] src_base = AW'(SRC), dst_base = AW'(DST);
    logic          m_cyc, m_stb, m_we, m_ack, ld_p, ld_c, ld_n, sh, done, irq;
    logic [AW-1:0] m_adr;

    stencil_seq #(.IMG_W(W), .IMG_H(H), .PIX_PER_WORD(PPW), .AW(AW)) uut (
        .clk_i(clk), .rst_i(rst), .start_i(start), .irq_en_i(irq_en),
        .status_rd_i(status_rd), .src_base_i(src_base), .dst_base_i(dst_base),
        .m_cyc_o(m_cyc), .m_stb_o(m_stb), .m_we_o(m_we), .m_adr_o(m_adr),
        .m_ack_i(m_ack), .ld_prev_o(ld_p), .ld_curr_o(ld_c), .ld_next_o(ld_n),
        .shift_en_o(sh), .done_o(done), .irq_o(irq)
    );

    int n_total = 0, n_fail = 0;
    logic [7:0]  img [0:H-1][0:W-1];
    logic [31:0] mem [0:4095];

    // ---------------- memory model with log ----------------
    int          wait_cfg = 0;
    int          wcnt;
    logic [31:0] rdata;
    logic        log_clr = 1'b0;
    logic        acc_we  [0:255];
    int          acc_adr [0:255];
    int          acc_n;
    logic [31:0] res;

    initial m_ack = 1'b0;
    always @(posedge clk) begin
        if (rst || log_clr) acc_n <= 0;
        if (rst) begin
            m_ack <= 1'b0;
            wcnt  <= 0;
        end else if (m_cyc && m_stb && !m_ack) begin
            if (wcnt >= wait_cfg) begin
                m_ack <= 1'b1;
                wcnt  <= 0;
                if (m_we) mem[m_adr] <= res;
                else      rdata      <= mem[m_adr];
                if (!log_clr && acc_n < 256) begin
                    acc_we[acc_n]  <= m_we;
                    acc_adr[acc_n] <= int'(m_adr);
                    acc_n          <= acc_n + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            m_ack <= 1'b0;
        end
    end

    // ---------------- window pipeline model ----------------
    logic [31:0] rp, rc, rn;
    logic [7:0]  w [0:2][0:2];
    int          dx, dy;
    logic [7:0]  absd;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    always @(posedge clk) begin
        if (ld_p) rp <= rdata;
        if (ld_c) rc <= rdata;
        if (ld_n) rn <= rdata;
        if (sh) begin
            rp <= rp << 8; rc <= rc << 8; rn <= rn << 8;
            for (int i = 0; i < 3; i++) begin
                w[i][0] <= w[i][1];
                w[i][1] <= w[i][2];
            end
            w[0][2] <= rp[31:24];
            w[1][2] <= rc[31:24];
            w[2][2] <= rn[31:24];
            dx <= int'(w[0][2]) + 2*int'(w[1][2]) + int'(w[2][2])
                - int'(w[0][0]) - 2*int'(w[1][0]) - int'(w[2][0]);
            dy <= int'(w[0][0]) + 2*int'(w[0][1]) + int'(w[0][2])
                - int'(w[2][0]) - 2*int'(w[2][1]) - int'(w[2][2]);
            absd <= 8'((iabs(dx) + iabs(dy)) >> 3);
            res  <= {res[23:0], absd};
        end
    end

    // ---------------- port monitor ----------------
    logic          mon_clr = 1'b0;
    logic          pend_q;
    logic [AW-1:0] adr_q;
    logic          we_q;
    int hold_err, shift_n, overlap_n, run_len, run_err, ld_err;

    always @(negedge clk) begin
        if (rst || mon_clr) begin
            pend_q <= 1'b0; hold_err <= 0; shift_n <= 0; overlap_n <= 0;
            run_len <= 0; run_err <= 0; ld_err <= 0;
        end else begin
            if (pend_q && !(m_cyc && m_adr == adr_q && m_we == we_q))
                hold_err <= hold_err + 1;
            pend_q <= m_cyc && !m_ack;
            adr_q  <= m_adr;
            we_q   <= m_we;
            if (sh) begin
                shift_n <= shift_n + 1;
                run_len <= run_len + 1;
                if (m_cyc) overlap_n <= overlap_n + 1;
            end else if (run_len != 0) begin
                if (run_len != PPW) run_err <= run_err + 1;
                run_len <= 0;
            end
            if ((ld_p || ld_c || ld_n) && !(m_ack && !m_we)) ld_err <= ld_err + 1;
            if ((32'(ld_p) + 32'(ld_c) + 32'(ld_n)) > 1) ld_err <= ld_err + 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ref_pix(input int r, input int c);
        int gx, gy;
        gx = int'(img[r-1][c+1]) + 2*int'(img[r][c+1]) + int'(img[r+1][c+1])
           - int'(img[r-1][c-1]) - 2*int'(img[r][c-1]) - int'(img[r+1][c-1]);
        gy = int'(img[r-1][c-1]) + 2*int'(img[r-1][c]) + int'(img[r-1][c+1])
           - int'(img[r+1][c-1]) - 2*int'(img[r+1][c]) - int'(img[r+1][c+1]);
        return ((iabs(gx) + iabs(gy)) >> 3) & 255;
    endfunction

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        @(negedge clk);
        check(!m_cyc && !m_we, "R1 bus idle after reset", int'(m_cyc), 0);
        check(!ld_p && !ld_c && !ld_n && !sh, "R1 strobes low after reset",
              int'({ld_p, ld_c, ld_n, sh}), 0);
        check(!done && !irq, "R1 done/irq low after reset", int'({done, irq}), 0);
    endtask

    task automatic t_idle_status;
        irq_en = 1'b1;
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        @(negedge clk);
        check(!done && !irq && !m_cyc, "R11 no irq without done", int'(irq), 0);
        irq_en = 1'b0;
    endtask

    task automatic t_frame(input int wcfg, input bit en, input bit busy_start, input string tag);
        int idx, bad, first_act, first_exp, ebad;
        wait_cfg = wcfg;
        irq_en   = en;
        for (int a = DST; a < DST + OR * WPR; a++) mem[a] = 32'h0;
        log_clr = 1'b1; mon_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0; mon_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (busy_start) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(20000);
        check(done, {tag, " R10 done raised"}, int'(done), 1);
        check(!m_cyc && !sh, {tag, " R10 idle after done"}, int'({m_cyc, sh}), 0);
        check(irq == en, {tag, " R11 irq follows enable"}, int'(irq), int'(en));

        // access sequence
        check(acc_n == NACC, {tag, " R8 access count"}, acc_n, NACC);
        check(acc_we[0] == 1'b0 && acc_adr[0] == SRC, {tag, " R2 R12 first access read at source base"},
              acc_adr[0], SRC);
        bad = 0; idx = 0; first_act = 0; first_exp = 0;
        for (int r = 0; r < OR; r++) begin
            for (int g = 0; g < WPR + 2; g++) begin
                if (g >= 2) begin
                    if (idx < acc_n && !(acc_we[idx] && acc_adr[idx] == DST + r*WPR + g - 2)) begin
                        if (bad == 0) begin first_act = acc_adr[idx]; first_exp = DST + r*WPR + g - 2; end
                        bad++;
                    end
                    idx++;
                end
                if (g < WPR) begin
                    for (int k = 0; k < 3; k++) begin
                        if (idx < acc_n && !(!acc_we[idx] && acc_adr[idx] == SRC + r*WPR + g + k*WPR)) begin
                            if (bad == 0) begin first_act = acc_adr[idx]; first_exp = SRC + r*WPR + g + k*WPR; end
                            bad++;
                        end
                        idx++;
                    end
                end
            end
        end
        check(bad == 0, {tag, " R3 R8 access order and addresses"}, first_act, first_exp);
        check(!acc_we[5] && acc_we[6], {tag, " R6 first write after two groups"},
              int'({acc_we[5], acc_we[6]}), 1);
        check(!acc_we[4*WPR-3] && acc_we[4*WPR-2] && acc_we[4*WPR-1],
              {tag, " R7 row ends with two writes"},
              int'({acc_we[4*WPR-3], acc_we[4*WPR-2], acc_we[4*WPR-1]}), 3);

        // strobe behaviour
        check(shift_n == OR * (WPR + 1) * PPW, {tag, " R5 R7 shift cycles incl drain"},
              shift_n, OR * (WPR + 1) * PPW);
        check(run_err == 0 && overlap_n == 0, {tag, " R5 shift runs and bus quiet"},
              run_err + overlap_n, 0);
        check(ld_err == 0, {tag, " R3 load strobes on read ack only"}, ld_err, 0);
        check(hold_err == 0, {tag, " R4 request held stable"}, hold_err, 0);

        // data
        ebad = 0; first_act = 0; first_exp = 0;
        for (int r = 0; r < OR; r++)
            for (int g = 0; g < WPR; g++)
                for (int k = 0; k < PPW; k++) begin
                    int c, got, exp;
                    c = g * PPW + k;
                    if (c >= 1 && c <= W - 2) begin
                        got = int'(mem[DST + r*WPR + g][31 - 8*k -: 8]);
                        exp = ref_pix(r + 1, c);
                        if (got != exp) begin
                            if (ebad == 0) begin first_act = got; first_exp = exp; end
                            ebad++;
                        end
                    end
                end
        check(ebad == 0, {tag, " R9 result pixels vs stencil"}, first_act, first_exp);

        // done persistence, irq gating and clear
        repeat (5) @(negedge clk);
        check(done, {tag, " R10 done persists"}, int'(done), 1);
        irq_en = ~en;
        @(negedge clk);
        check(irq == ~en, {tag, " R11 irq tracks enable change"}, int'(irq), int'(~en));
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        check(!done && !irq, {tag, " R10 status read clears done"}, int'(done), 0);
        irq_en = 1'b0;
    endtask

    // ---------------- main ----------------
    initial begin
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                img[r][c] = 8'((r * 37 + c * 53 + ((r * c) % 17) * 11 + ((c > 7) ? 90 : 0)) & 255);
        for (int a = 0; a < 4096; a++) mem[a] = 32'h0;
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                mem[SRC + r*WPR + c/PPW][31 - 8*(c%PPW) -: 8] = img[r][c];
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle_status();
        t_frame(0, 1'b1, 1'b0, "frame1");
        t_frame(2, 1'b0, 1'b1, "frame2");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule